// File: doc/BRIEF.md
# Write-Once Element Store with Deferred Reads

This block is a small on-chip store in which every element is written once and may be read any number of times. Each element keeps a state (absent, waiting, present), its value and the head of a list of reads that arrived before the value did. Requests come in on one valid/ready port. There are three kinds: allocate a run of elements, fetch an element, and store an element. Replies leave on a response port and carry the requester's tag, so a requester issues a fetch and later matches the reply by tag without ever stalling on the value.

A fetch to an unwritten element is not refused. Its tag is placed in a shared pool of fixed depth, threaded as a linked list from the element's head pointer, and the element becomes waiting. When the single permitted store arrives, the block writes the value, marks the element present and then walks the list, answering one deferred read per cycle. New requests are held off while this walk runs. A second store to a present element is dropped and raises a one-cycle error pulse. Allocation hands out consecutive elements from a bump pointer and refuses a request that does not fit in the remaining space.

Top module: `istore_ctrl`

## Requirements
- R1: After reset `rsp_valid` and `err_dup_store` are 0, `req_ready` is 1 and every element is absent. The first allocate returns base 0.
- R2: A fetch (`req_op` = 1) accepted at a clock edge for a present element produces a response right after that edge. The response has `rsp_kind` = 1, `rsp_ok` = 1, the request's tag and the stored value.
- R3: A store (`req_op` = 2) to a present element leaves the value unchanged and produces no response. It pulses `err_dup_store` for exactly one cycle right after the accepting edge.
- R4: A fetch to an absent or waiting element produces no response when accepted. It is held as a deferred read and the element becomes waiting.
- R5: A store to a waiting element writes the value and makes the element present. Starting one cycle after the accepting edge, it emits one response per cycle for each deferred read of that element, with `rsp_kind` = 1, `rsp_ok` = 1 and the new value. The reads are answered most recent first. After the last of them no further response is emitted.
- R6: `req_ready` is 0 from the edge that accepts a store to a waiting element until the edge that emits its last deferred response. It is 1 again from that edge on.
- R7: An allocate (`req_op` = 0) with count N in `req_data` responds right after acceptance with `rsp_kind` = 0 and `rsp_data` = the current base. If base+N is at most DEPTH, `rsp_ok` is 1 and the base advances by N. Otherwise `rsp_ok` is 0 and the base is unchanged.
- R8: When all POOL deferred-read slots are in use, `req_ready` is 0 while `req_op` is fetch and stays 1 for store and allocate. A deferred-read replay frees the slots.
- R9: A store to an absent element produces no response and no error, and a later fetch returns its value.
- R10: An allocate that succeeds returns every element in its range to absent, even one that was stored before the allocation reached it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid is also high |
| req_op | input | 2 | 0 allocate, 1 fetch, 2 store, 3 no operation |
| req_addr | input | $clog2(DEPTH) | Element index for fetch and store |
| req_data | input | DW | Store value, or element count for allocate |
| req_tag | input | TW | Requester identifier echoed in the reply |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_kind | output | 2 | 0 allocate reply, 1 fetch reply |
| rsp_ok | output | 1 | 1 on success, 0 on failed allocate |
| rsp_tag | output | TW | Tag of the request being answered |
| rsp_data | output | DW | Fetched value or allocation base |
| err_dup_store | output | 1 | One-cycle pulse on a store to a present element |

## Verification
Every element of a 16-entry store is stored and then fetched with a value computed from its index, which separates address decoding from value storage. A second store then checks that the first value survives. The remaining elements get one to four fetches before their store, with distinct tags. This exposes list linkage and ordering faults, a lost or duplicated replay, and the length of the back-pressure window. A run of allocations that fits exactly, followed by ones that overflow, pins down the capacity arithmetic. A pool filled to its last slot shows that only fetches are held back.

// File: rtl/istore_pkg.sv
// Shared types for the write-once element store.
// Assumes: request opcodes and element states are encoded in two bits.
package istore_pkg;
    typedef enum logic [1:0] {
        OP_ALLOC = 2'd0,
        OP_FETCH = 2'd1,
        OP_STORE = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_ABSENT  = 2'd0,
        ST_WAITING = 2'd1,
        ST_PRESENT = 2'd2
    } elem_st_e;
endpackage

// File: rtl/istore_defer_pool.sv
// Shared pool of deferred-read slots; each slot holds a requester tag and a
// link to the next slot of the same element's list (MSB of a link = end).
// Assumes: push and pop never happen in the same cycle (the controller
// stops accepting requests while it pops).
module istore_defer_pool #(
    parameter int POOL = 8,
    parameter int TW   = 4,
    localparam int IW  = $clog2(POOL),
    localparam int LW  = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_en,
    input  logic [TW-1:0] push_tag,
    input  logic [LW-1:0] push_next,
    input  logic          pop_en,
    input  logic [IW-1:0] rd_idx,
    output logic          full,
    output logic [IW-1:0] free_idx,
    output logic [TW-1:0] rd_tag,
    output logic [LW-1:0] rd_next
);
    logic [POOL-1:0] busy_q;
    logic [TW-1:0]   tag_q  [POOL];
    logic [LW-1:0]   next_q [POOL];

    // Lowest-numbered free slot.
    always_comb begin
        free_idx = '0;
        for (int i = POOL - 1; i >= 0; i--) begin
            if (!busy_q[i]) free_idx = IW'(i);
        end
    end

    // Pool is full when no slot is free.
    assign full    = &busy_q;
    assign rd_tag  = tag_q[rd_idx];
    assign rd_next = next_q[rd_idx];

    // Slot allocation, release and contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
            for (int i = 0; i < POOL; i++) begin
                tag_q[i]  <= '0;
                next_q[i] <= '0;
            end
        end else begin
            if (push_en) begin
                busy_q[free_idx] <= 1'b1;
                tag_q[free_idx]  <= push_tag;
                next_q[free_idx] <= push_next;
            end
            if (pop_en) busy_q[rd_idx] <= 1'b0;
        end
    end

    AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> !full); // R8
    AST_POP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> busy_q[rd_idx]); // R5
endmodule

// File: rtl/istore_elem_table.sv
// Per-element state, value and deferred-list head, addressed by one index.
// Assumes: the controller writes a value only into a non-present element
// and clears a range only on a successful allocation.
module istore_elem_table
    import istore_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 16,
    parameter int LW    = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    output elem_st_e      rd_st,
    output logic [DW-1:0] rd_val,
    output logic [LW-1:0] rd_head,
    input  logic          wr_val_en,
    input  logic [DW-1:0] wr_val,
    input  logic          wr_wait_en,
    input  logic [LW-1:0] wr_head,
    input  logic          clr_en,
    input  logic [CW-1:0] clr_lo,
    input  logic [CW-1:0] clr_hi
);
    elem_st_e      st_q   [DEPTH];
    logic [DW-1:0] val_q  [DEPTH];
    logic [LW-1:0] head_q [DEPTH];

    assign rd_st   = st_q[addr];
    assign rd_val  = val_q[addr];
    assign rd_head = head_q[addr];

    // State, value and list-head updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_q[i]   <= ST_ABSENT;
                val_q[i]  <= '0;
                head_q[i] <= '0;
            end
        end else begin
            if (clr_en) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CW'(i) >= clr_lo && CW'(i) < clr_hi) st_q[i] <= ST_ABSENT;
                end
            end
            if (wr_val_en) begin
                st_q[addr]  <= ST_PRESENT;
                val_q[addr] <= wr_val;
            end
            if (wr_wait_en) begin
                st_q[addr]   <= ST_WAITING;
                head_q[addr] <= wr_head;
            end
        end
    end

    AST_WRITE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_val_en |-> st_q[addr] != ST_PRESENT); // R3
    AST_DEFER_UNWRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_wait_en |-> st_q[addr] != ST_PRESENT); // R4
endmodule

// File: rtl/istore_ctrl.sv
// Write-once element store controller: decodes allocate/fetch/store requests,
// answers fetches of present elements, defers the others into the shared
// pool, and replays a deferred list one response per cycle after its store.
// Assumes: DW+1 >= $clog2(DEPTH)+1 and POOL >= 2.
module istore_ctrl
    import istore_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 16,
    parameter int TW    = 4,
    parameter int POOL  = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1,
    localparam int IW   = $clog2(POOL),
    localparam int LW   = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic [TW-1:0] req_tag,
    output logic          rsp_valid,
    output logic [1:0]    rsp_kind,
    output logic          rsp_ok,
    output logic [TW-1:0] rsp_tag,
    output logic [DW-1:0] rsp_data,
    output logic          err_dup_store
);
    localparam logic [LW-1:0] NIL = {1'b1, {IW{1'b0}}};

    op_e           op;
    logic          acc, fetch_hit, defer, store_ok, dup, start_rp;
    logic          alloc_acc, alloc_ok;
    logic [DW:0]   alloc_end;
    elem_st_e      el_st;
    logic [DW-1:0] el_val;
    logic [LW-1:0] el_head;
    logic          pool_full;
    logic [IW-1:0] pool_free;
    logic [TW-1:0] pool_tag;
    logic [LW-1:0] pool_next;
    logic          in_replay_q;
    logic [LW-1:0] rp_ptr_q;
    logic [DW-1:0] rp_val_q;
    logic [CW-1:0] bump_q;

    // Request decode and handshake.
    always_comb begin
        op        = op_e'(req_op);
        req_ready = !in_replay_q && !(pool_full && op == OP_FETCH);
        acc       = req_valid && req_ready;
        fetch_hit = acc && op == OP_FETCH && el_st == ST_PRESENT;
        defer     = acc && op == OP_FETCH && el_st != ST_PRESENT;
        store_ok  = acc && op == OP_STORE && el_st != ST_PRESENT;
        dup       = acc && op == OP_STORE && el_st == ST_PRESENT;
        start_rp  = store_ok && el_st == ST_WAITING;
        alloc_acc = acc && op == OP_ALLOC;
        alloc_end = (DW+1)'(bump_q) + {1'b0, req_data};
        alloc_ok  = alloc_end <= (DW+1)'(DEPTH);
    end

    istore_elem_table #(.DEPTH(DEPTH), .DW(DW), .LW(LW)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (req_addr),
        .rd_st      (el_st),
        .rd_val     (el_val),
        .rd_head    (el_head),
        .wr_val_en  (store_ok),
        .wr_val     (req_data),
        .wr_wait_en (defer),
        .wr_head    ({1'b0, pool_free}),
        .clr_en     (alloc_acc && alloc_ok),
        .clr_lo     (bump_q),
        .clr_hi     (CW'(alloc_end))
    );

    istore_defer_pool #(.POOL(POOL), .TW(TW)) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (defer),
        .push_tag  (req_tag),
        .push_next ((el_st == ST_WAITING) ? el_head : NIL),
        .pop_en    (in_replay_q),
        .rd_idx    (rp_ptr_q[IW-1:0]),
        .full      (pool_full),
        .free_idx  (pool_free),
        .rd_tag    (pool_tag),
        .rd_next   (pool_next)
    );

    // Responses, error pulse, replay walk and allocation pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_kind      <= 2'd0;
            rsp_ok        <= 1'b0;
            rsp_tag       <= '0;
            rsp_data      <= '0;
            err_dup_store <= 1'b0;
            in_replay_q   <= 1'b0;
            rp_ptr_q      <= NIL;
            rp_val_q      <= '0;
            bump_q        <= '0;
        end else begin
            rsp_valid     <= 1'b0;
            err_dup_store <= 1'b0;
            if (in_replay_q) begin
                rsp_valid <= 1'b1;
                rsp_kind  <= OP_FETCH;
                rsp_ok    <= 1'b1;
                rsp_tag   <= pool_tag;
                rsp_data  <= rp_val_q;
                rp_ptr_q  <= pool_next;
                if (pool_next[LW-1]) in_replay_q <= 1'b0;
            end
            if (alloc_acc) begin
                rsp_valid <= 1'b1;
                rsp_kind  <= OP_ALLOC;
                rsp_ok    <= alloc_ok;
                rsp_tag   <= req_tag;
                rsp_data  <= DW'(bump_q);
                if (alloc_ok) bump_q <= CW'(alloc_end);
            end
            if (fetch_hit) begin
                rsp_valid <= 1'b1;
                rsp_kind  <= OP_FETCH;
                rsp_ok    <= 1'b1;
                rsp_tag   <= req_tag;
                rsp_data  <= el_val;
            end
            if (start_rp) begin
                in_replay_q <= 1'b1;
                rp_ptr_q    <= el_head;
                rp_val_q    <= req_data;
            end
            if (dup) err_dup_store <= 1'b1;
        end
    end

    AST_NO_ACCEPT_IN_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
        in_replay_q |-> !req_ready); // R6
    AST_DUP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        err_dup_store |-> !rsp_valid); // R3
    AST_BUMP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        bump_q <= CW'(DEPTH)); // R7
    AST_REPLAY_LINK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        in_replay_q |-> !rp_ptr_q[LW-1]); // R5
endmodule

// File: tb/tb_istore_ctrl.sv
module tb_istore_ctrl;
    localparam int DEPTH = 16;
    localparam int DW    = 16;
    localparam int TW    = 4;
    localparam int POOL  = 8;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic [1:0]    req_op;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_data;
    logic [TW-1:0] req_tag;
    logic          rsp_valid;
    logic [1:0]    rsp_kind;
    logic          rsp_ok;
    logic [TW-1:0] rsp_tag;
    logic [DW-1:0] rsp_data;
    logic          err_dup_store;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    istore_ctrl #(.DEPTH(DEPTH), .DW(DW), .TW(TW), .POOL(POOL)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_ok(rsp_ok),
        .rsp_tag(rsp_tag), .rsp_data(rsp_data), .err_dup_store(err_dup_store)
    );

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0;
        req_addr = '0; req_data = '0; req_tag = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Issue one request; returns at the negedge after the accepting edge.
    task automatic send(input int op, input int addr, input int data, input int tag);
        @(negedge clk);
        req_valid = 1'b1; req_op = op[1:0]; req_addr = addr[AW-1:0];
        req_data = data[DW-1:0]; req_tag = tag[TW-1:0];
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_fetch_rsp(input string rq, input int tag, input int val);
        chk(rq, "rsp_valid", rsp_valid, 1);
        chk(rq, "rsp_kind", rsp_kind, 1);
        chk(rq, "rsp_ok", rsp_ok, 1);
        chk(rq, "rsp_tag", rsp_tag, tag);
        chk(rq, "rsp_data", rsp_data, val);
    endtask

    task automatic chk_alloc(input int n, input int base, input int ok);
        send(0, 0, n, 7);
        chk("R7", "alloc rsp_valid", rsp_valid, 1);
        chk("R7", "alloc rsp_kind", rsp_kind, 0);
        chk("R7", "alloc rsp_ok", rsp_ok, ok);
        chk("R7", "alloc base", rsp_data, base);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait (cyc >= 50000);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1: idle outputs after reset
        #1;
        chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "err", err_dup_store, 0);
        chk("R1", "req_ready", req_ready, 1);

        // R9: store to absent element, then fetch sees it
        send(2, 15, 1234, 0);
        chk("R9", "no rsp", rsp_valid, 0);
        chk("R9", "no err", err_dup_store, 0);
        send(1, 15, 0, 5);
        chk_fetch_rsp("R2", 5, 1234);

        // R7 / R1: allocation arithmetic, first base is 0
        chk_alloc(4, 0, 1);
        chk_alloc(10, 4, 1);
        chk_alloc(3, 14, 0);
        chk_alloc(2, 14, 1);
        chk_alloc(1, 16, 0);

        // R10: element 15 was re-initialised by allocation, so fetch is deferred
        send(1, 15, 0, 6);
        chk("R10", "fetch deferred", rsp_valid, 0);
        send(2, 15, 777, 0);
        chk("R10", "replay pending", rsp_valid, 0);
        @(negedge clk);
        chk_fetch_rsp("R10", 6, 777);

        // Sweep: store, fetch, duplicate store, fetch again
        for (int a = 0; a < 8; a++) begin
            int v = (a * 1111 + 3) & 16'hffff;
            send(2, a, v, 0);
            chk("R9", "store no rsp", rsp_valid, 0);
            chk("R9", "store no err", err_dup_store, 0);
            send(1, a, 0, a);
            chk_fetch_rsp("R2", a, v);
            send(2, a, v ^ 16'h5a5a, 0);
            chk("R3", "dup err", err_dup_store, 1);
            chk("R3", "dup no rsp", rsp_valid, 0);
            @(negedge clk);
            chk("R3", "err one cycle", err_dup_store, 0);
            send(1, a, 0, (a + 3) % 16);
            chk_fetch_rsp("R3", (a + 3) % 16, v);
        end

        // Deferred reads: 1..4 fetches before the store, replayed newest first
        for (int a = 8; a < 15; a++) begin
            int k = (a % 4) + 1;
            int w = (a * 257 + 9) & 16'hffff;
            for (int j = 0; j < k; j++) begin
                send(1, a, 0, (a + j) % 16);
                chk("R4", "deferred no rsp", rsp_valid, 0);
            end
            send(2, a, w, 0);
            chk("R5", "no rsp at store", rsp_valid, 0);
            chk("R6", "ready low in replay", req_ready, 0);
            for (int j = k - 1; j >= 0; j--) begin
                @(negedge clk);
                chk_fetch_rsp("R5", (a + j) % 16, w);
                chk("R6", "ready during replay", req_ready, (j == 0) ? 1 : 0);
            end
            @(negedge clk);
            chk("R5", "replay ended", rsp_valid, 0);
            send(1, a, 0, 9);
            chk_fetch_rsp("R5", 9, w);
        end

        // R8: fill the pool, then only fetch is held back
        do_reset();
        for (int i = 0; i < POOL; i++) begin
            send(1, i, 0, i);
            chk("R4", "fill no rsp", rsp_valid, 0);
        end
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd1; req_addr = '0;
        #1 chk("R8", "ready for fetch when full", req_ready, 0);
        req_op = 2'd0;
        #1 chk("R8", "ready for alloc when full", req_ready, 1);
        req_op = 2'd2;
        #1 chk("R8", "ready for store when full", req_ready, 1);
        req_valid = 1'b0;
        send(2, 3, 4321, 0);
        @(negedge clk);
        chk_fetch_rsp("R8", 3, 4321);
        req_op = 2'd1;
        #1 chk("R8", "ready for fetch after drain", req_ready, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule